// File: doc/BRIEF.md
# Majority-Vote Read Filter

This block stands in front of a read port that occasionally returns a corrupted word, typically a register living in a slow clock domain. On a start pulse it reads the target repeatedly, builds a histogram of the distinct words it has seen, and reports the word seen most often. A clean read stream ends the session early: once one word holds a strict majority of the planned sample count, no further reads are issued.

Each returned sample is looked up in a table of distinct words. The lookup walks the table one entry per clock from the first entry until it finds the same word or the first unused slot. A found word has its count raised by one; an unused slot receives the word with a count of one. A running best count and best word are updated only when a count becomes strictly larger than the best so far, so on equal counts the word that got there first is kept.

Top module: `majority_read_filter`

## Requirements
- R1: After reset `busy_o`, `done_o` and `rd_req_o` are low and `result_o` is zero.
- R2: A `start_i` pulse seen while idle raises `busy_o` on the next cycle; the block then issues one-cycle `rd_req_o` pulses, one per sample, and issues the next only after `rd_ack_i` has returned the previous sample (any acknowledge latency of one cycle or more).
- R3: The reported word is the one returned most often within the session; repeats of a word add to its count and new words enter the table with a count of one.
- R4: When two words finish with equal counts, the word whose count reached that value first is reported.
- R5: As soon as one word's count exceeds SAMPLES/2 (integer division; 51 for the default of 100), the session ends and no further read is requested.
- R6: Without such a majority the session issues exactly SAMPLES read requests.
- R7: `done_o` is high for exactly one cycle at the end of a session, `result_o` carries the winner in that cycle and holds it until the next session ends, and `busy_o` stays high through the `done_o` cycle and is low on the cycle after.
- R8: A `start_i` pulse while `busy_o` is high has no effect: the running session's request count and result are unchanged.
- R9: Each session starts with an empty table and best count, so words counted in a previous session do not influence the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a session when idle |
| rd_req_o | output | 1 | One-cycle request for one read of the target |
| rd_ack_i | input | 1 | Target indicates `rd_data_i` holds the requested word |
| rd_data_i | input | DATA_W | Word returned by the target |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse marking the end of a session |
| result_o | output | DATA_W | Most frequent word of the last finished session |

## Verification
On every cycle the assertions watch the request handshake (single-cycle requests, only while busy), the one-cycle done pulse, that a busy session survives a stray start, that the table fill and sample counters stay within SAMPLES, that a clear empties the table, and that the best count never falls inside a session. Which word wins, the tie rule, the exact point of early termination and the full-length count can only be shown by the bench's sessions, which feed chosen read streams (uniform, alternating in both orders, noise followed by a steady word, all distinct, two-to-one mix) at several acknowledge latencies and compare the reported word and the number of reads against values worked out by hand.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_SCAN = 3'd3,
        ST_FIN  = 3'd4
    } mvf_state_e;

endpackage

// File: rtl/mvf_hist_table.sv
module mvf_hist_table #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 100,
    parameter int LEN_W  = $clog2(DEPTH + 1),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [LEN_W-1:0]  probe_idx_i,
    output logic [DATA_W-1:0] probe_val_o,
    output logic [CNT_W-1:0]  probe_cnt_o,
    input  logic              wr_en_i,
    input  logic              append_i,
    input  logic [LEN_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  logic [CNT_W-1:0]  wr_cnt_i,
    output logic [LEN_W-1:0]  fill_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] val_mem [DEPTH];
    logic [CNT_W-1:0]  cnt_mem [DEPTH];
    logic [LEN_W-1:0]  fill_d, fill_q;
    logic [IDX_W-1:0]  probe_idx, wr_idx;

    assign probe_idx   = probe_idx_i[IDX_W-1:0];
    assign wr_idx      = wr_idx_i[IDX_W-1:0];
    assign probe_val_o = val_mem[probe_idx];
    assign probe_cnt_o = cnt_mem[probe_idx];
    assign fill_o      = fill_q;

    always_comb begin
        fill_d = fill_q;
        if (clear_i) begin
            fill_d = '0;
        end else if (wr_en_i && append_i) begin
            fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            val_mem[wr_idx] <= wr_val_i;
            cnt_mem[wr_idx] <= wr_cnt_i;
        end
    end

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= LEN_W'(DEPTH)); // R3
    AST_FILL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fill_q == '0)); // R9

endmodule

// File: rtl/mvf_max_track.sv
module mvf_max_track #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [CNT_W-1:0]  upd_cnt_i,
    input  logic [DATA_W-1:0] upd_val_i,
    output logic [CNT_W-1:0]  best_cnt_nxt_o,
    output logic [DATA_W-1:0] best_val_nxt_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] val;
    } best_t;

    best_t best_d, best_q;

    always_comb begin
        best_d = best_q;
        if (clear_i) begin
            best_d = '0;
        end else if (upd_i && (upd_cnt_i > best_q.cnt)) begin
            best_d.cnt = upd_cnt_i;
            best_d.val = upd_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q <= '0;
        end else begin
            best_q <= best_d;
        end
    end

    assign best_cnt_nxt_o = best_d.cnt;
    assign best_val_nxt_o = best_d.val;

    AST_BEST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (best_q.cnt >= $past(best_q.cnt))); // R4

endmodule

// File: rtl/majority_read_filter.sv
module majority_read_filter
    import mvf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SAMPLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int LEN_W = $clog2(SAMPLES + 1);
    localparam int CNT_W = $clog2(SAMPLES + 1);
    localparam int HALF  = SAMPLES / 2;

    typedef struct packed {
        mvf_state_e        state;
        logic [DATA_W-1:0] sample;
        logic [LEN_W-1:0]  scan;
        logic [CNT_W-1:0]  taken;
        logic [DATA_W-1:0] result;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tbl_clear;
    logic              tbl_wr_en;
    logic              tbl_append;
    logic [CNT_W-1:0]  tbl_wr_cnt;
    logic [DATA_W-1:0] probe_val;
    logic [CNT_W-1:0]  probe_cnt;
    logic [LEN_W-1:0]  fill;
    logic [CNT_W-1:0]  best_cnt_nxt;
    logic [DATA_W-1:0] best_val_nxt;
    logic              at_empty;
    logic              at_match;

    mvf_hist_table #(
        .DATA_W (DATA_W),
        .DEPTH  (SAMPLES),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (tbl_clear),
        .probe_idx_i (ctl_q.scan),
        .probe_val_o (probe_val),
        .probe_cnt_o (probe_cnt),
        .wr_en_i     (tbl_wr_en),
        .append_i    (tbl_append),
        .wr_idx_i    (ctl_q.scan),
        .wr_val_i    (ctl_q.sample),
        .wr_cnt_i    (tbl_wr_cnt),
        .fill_o      (fill)
    );

    mvf_max_track #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (tbl_clear),
        .upd_i          (tbl_wr_en),
        .upd_cnt_i      (tbl_wr_cnt),
        .upd_val_i      (ctl_q.sample),
        .best_cnt_nxt_o (best_cnt_nxt),
        .best_val_nxt_o (best_val_nxt)
    );

    assign at_empty = (ctl_q.scan == fill);
    assign at_match = !at_empty && (probe_val == ctl_q.sample);

    always_comb begin
        ctl_d      = ctl_q;
        tbl_clear  = 1'b0;
        tbl_wr_en  = 1'b0;
        tbl_append = 1'b0;
        tbl_wr_cnt = '0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    tbl_clear   = 1'b1;
                    ctl_d.scan  = '0;
                    ctl_d.taken = '0;
                    ctl_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_ack_i) begin
                    ctl_d.sample = rd_data_i;
                    ctl_d.scan   = '0;
                    ctl_d.state  = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (at_empty || at_match) begin
                    tbl_wr_en   = 1'b1;
                    tbl_append  = at_empty;
                    tbl_wr_cnt  = at_empty ? CNT_W'(1) : probe_cnt + 1'b1;
                    ctl_d.taken = ctl_q.taken + 1'b1;
                    if ((best_cnt_nxt > CNT_W'(HALF)) ||
                        (ctl_q.taken == CNT_W'(SAMPLES - 1))) begin
                        ctl_d.result = best_val_nxt;
                        ctl_d.state  = ST_FIN;
                    end else begin
                        ctl_d.state = ST_REQ;
                    end
                end else begin
                    ctl_d.scan = ctl_q.scan + 1'b1;
                end
            end
            ST_FIN: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_o = (ctl_q.state == ST_REQ);
    assign busy_o   = (ctl_q.state != ST_IDLE);
    assign done_o   = (ctl_q.state == ST_FIN);
    assign result_o = ctl_q.result;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o); // R2
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R8
    AST_SAMPLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.taken <= CNT_W'(SAMPLES)); // R6

endmodule

// File: tb/majority_read_filter_test.sv
`timescale 1ns/1ps
module majority_read_filter_test;
    localparam int DW = 32;
    localparam int NS = 100;
    localparam logic [DW-1:0] WA    = 32'hCAFE_0001;
    localparam logic [DW-1:0] WB    = 32'h5A5A_F00D;
    localparam logic [DW-1:0] WBASE = 32'h1000_0000;

    typedef struct packed {
        logic [2:0]    pat;
        logic [1:0]    lat;
        logic [7:0]    reads;
        logic [DW-1:0] res;
    } vec_t;

    // pat 0: all A; 1: A,B alternating; 2: 10 noise then B; 3: all distinct;
    // 4: B when k%3==0 else A; 5: B,A alternating
    localparam vec_t VECS [6] = '{
        '{3'd0, 2'd1, 8'd51,  WA},
        '{3'd1, 2'd2, 8'd100, WA},
        '{3'd2, 2'd1, 8'd61,  WB},
        '{3'd3, 2'd3, 8'd100, WBASE},
        '{3'd4, 2'd1, 8'd77,  WA},
        '{3'd5, 2'd2, 8'd100, WB}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          rd_req_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [DW-1:0] result_o;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int sidx   = 0;
    int cur_pat = 0;
    int cur_lat = 1;
    int cycles = 0;
    bit finished = 1'b0;

    majority_read_filter #(.DATA_W(DW), .SAMPLES(NS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_req_o  (rd_req_o),
        .rd_ack_i  (rd_ack_i),
        .rd_data_i (rd_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] gen(int pat, int k);
        case (pat)
            0: return WA;
            1: return (k % 2 == 0) ? WA : WB;
            2: return (k < 10) ? (32'h0000_0100 + DW'(k)) : WB;
            3: return WBASE + DW'(k);
            4: return (k % 3 == 0) ? WB : WA;
            default: return (k % 2 == 0) ? WB : WA;
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // target model: answers each request after cur_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                int k;
                k = sidx;
                sidx++;
                reads++;
                repeat (cur_lat) @(negedge clk);
                rd_ack_i  = 1'b1;
                rd_data_i = gen(cur_pat, k);
                @(negedge clk);
                rd_ack_i  = 1'b0;
                rd_data_i = '0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic run_session(int pat, int lat, int exp_reads, logic [DW-1:0] exp_res,
                               bit poke_start, string tag);
        int wait_cnt;
        cur_pat = pat;
        cur_lat = lat;
        reads = 0;
        sidx = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {tag, " R2 busy after start"}, DW'(busy_o), 1);
        wait_cnt = 0;
        while (!done_o && wait_cnt < 40000) begin
            @(negedge clk);
            wait_cnt++;
            if (poke_start && wait_cnt == 30) start_i = 1'b1;
            if (poke_start && wait_cnt == 31) start_i = 1'b0;
        end
        check(done_o == 1'b1, {tag, " R7 done seen"}, DW'(done_o), 1);
        check(result_o == exp_res, {tag, " R3 result"}, result_o, exp_res);
        check(reads == exp_reads, {tag, " R5/R6 read count"}, DW'(reads), DW'(exp_reads));
        check(busy_o == 1'b1, {tag, " R7 busy in done cycle"}, DW'(busy_o), 1);
        @(negedge clk);
        check(!done_o && !busy_o, {tag, " R7 done single cycle"}, DW'({done_o, busy_o}), 0);
        repeat (5) @(negedge clk);
        check(result_o == exp_res, {tag, " R7 result held"}, result_o, exp_res);
        check(reads == exp_reads, {tag, " R5 no extra reads"}, DW'(reads), DW'(exp_reads));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !rd_req_o, "R1 reset outputs",
              DW'({busy_o, done_o, rd_req_o}), 0);
        check(result_o == '0, "R1 reset result", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o, "R1 idle after reset", DW'(busy_o), 0);

        // table-driven sessions; R4 ties in vectors 1 and 5, R9 by back-to-back runs
        for (int i = 0; i < 6; i++) begin
            run_session(int'(VECS[i].pat), int'(VECS[i].lat), int'(VECS[i].reads),
                        VECS[i].res, 1'b0, $sformatf("vec%0d", i));
        end

        // R8: start pulse mid-session is ignored
        run_session(4, 2, 77, WA, 1'b1, "R8 stray start");

        // R4 tie after distinct run, with different latency (R2)
        run_session(5, 3, 100, WB, 1'b0, "R4 tie B first");

        // R9: heavy B history, then uniform A must report A at 51 reads
        run_session(0, 1, 51, WA, 1'b0, "R9 fresh table");

        finish_run();
    end

endmodule